// File: doc/BRIEF.md
# Output Compare Timer Bank

A timer peripheral built around one free-running counter, 16 bits wide by default, that steps on a programmable power-of-two division of the clock. Eight channels watch the counter. A channel in compare mode raises its flag when the counter steps onto its compare value. In that same clock it applies a two-bit action to its own output pin: none, toggle, drive low or drive high. Software reaches every register through a single-cycle write strobe and a combinational read port.

The last channel has one extra function. When it matches, it forces every pin selected by a mask register to the level held in the matching bit of a data register. This forced level overrides any channel's own action on that pin. With the last channel forcing a pin low and a second channel driving it high, software can produce a pulse train. It does this by adding the period to the last channel's compare value and then loading the second channel with that sum plus the pulse width. Each channel requests an interrupt while its flag and its enable bit are both set.

Top module: `oc_timer_bank`

## Requirements
- R1: The counter (address 8, a write loads it) steps only while bit 7 of the control register (address 0) is 1, holds its value while that bit is 0, and wraps from all ones to zero.
- R2: The divider field, bits 2:0 of address 1, holds a value n that makes the counter step once every 2^n clocks: 0 steps on every clock and 2 steps on every fourth clock.
- R3: Bit i of the mode register (address 2) selects compare mode when 1; a channel whose bit is 0 never raises its flag nor changes any pin on a counter match.
- R4: Compare value i sits at address 16+i. When the counter steps onto the compare value of a compare-mode channel, bit i of the flag register (address 3) becomes 1 in the same clock; writing 1 to a flag bit clears it, writing 0 leaves it unchanged.
- R5: The action register (address 5) holds the field of channel i in bits 2i+1:2i: 00 leaves the pin alone, 01 toggles it, 10 drives it low, 11 drives it high, applied in the clock in which the counter reaches the compare value.
- R6: On a match of channel 7, every pin whose bit is set in the force mask (address 6) takes the value of the same bit of the force data (address 7); pins outside the mask are left to their own actions.
- R7: When a channel 7 forced value and a channel's own action reach the same pin in the same clock, the forced value wins.
- R8: Interrupt request i is 1 exactly while flag i and bit i of the enable register (address 4) are both 1.
- R9: A match acts once per counter value: with the divider above 1, a toggle action flips its pin only once while the counter rests on the compare value.
- R10: Loading channel 7 with a base plus the period and channel 6 with that value plus the width, with the force mask 0x40, force data 0 and channel 6 action 11, gives pin 6 low from the channel 7 match and high from the channel 6 match, and the cycle repeats after each reload.
- R11: After reset every register, the counter, all pins and all interrupt requests are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe, one write per clock |
| bus_addr | input | ADDR_W | Register address for reads and writes |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for bus_addr, combinational |
| pin_out | output | N_CH | Compare output pins |
| irq | output | N_CH | Per-channel interrupt requests |

## Verification
The bench targets divider ratios where an off-by-one in the prescaler moves the count by one step, and it reads the counter after a stop to catch a design that keeps counting with the run bit clear. It also rests the counter on a compare value for four clocks under a toggle action: a design that compares on every clock instead of on the step would leave the pin back where it started. It makes two channels match on the same step with conflicting levels on pin 6, where a design with the wrong priority would drive the pin high. It also writes zero to a set flag, which a design that assigns the register instead of clearing bits would lose. A closing pulse-train sequence reloads the compare values while the counter runs and checks both edges of two periods.

// File: rtl/oc_timer_pkg.sv
`timescale 1ns/1ps
package oc_timer_pkg;

    localparam int DIV_W = 3;

    localparam int ADR_CTRL  = 0;
    localparam int ADR_DIV   = 1;
    localparam int ADR_MODE  = 2;
    localparam int ADR_FLAG  = 3;
    localparam int ADR_IEN   = 4;
    localparam int ADR_ACT   = 5;
    localparam int ADR_FMASK = 6;
    localparam int ADR_FDATA = 7;
    localparam int ADR_COUNT = 8;
    localparam int RUN_BIT   = 7;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'b00,
        ACT_TOGGLE = 2'b01,
        ACT_LOW    = 2'b10,
        ACT_HIGH   = 2'b11
    } pin_act_e;

    typedef struct packed {
        logic             run;
        logic [DIV_W-1:0] div_sel;
    } tb_cfg_t;

    function automatic logic apply_act(pin_act_e act, logic cur);
        case (act)
            ACT_TOGGLE: return ~cur;
            ACT_LOW:    return 1'b0;
            ACT_HIGH:   return 1'b1;
            default:    return cur;
        endcase
    endfunction

endpackage

// File: rtl/oc_timebase.sv
`timescale 1ns/1ps
module oc_timebase
    import oc_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  tb_cfg_t          cfg,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             step,
    output logic [CNT_W-1:0] next_count
);
    localparam int PC_W = (1 << DIV_W) - 1;

    logic [PC_W-1:0] pcnt;
    logic [PC_W-1:0] lim;
    logic            tick;

    always_comb lim = {PC_W{1'b1}} >> (PC_W - int'(cfg.div_sel));

    assign tick       = cfg.run && (pcnt >= lim);
    assign step       = tick && !load;
    assign next_count = count + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            pcnt  <= '0;
            count <= '0;
        end else begin
            if (!cfg.run || tick) pcnt <= '0;
            else                  pcnt <= pcnt + 1'b1;
            if (load)      count <= load_val;
            else if (tick) count <= next_count;
        end
    end

    assert_stop_hold_R1: assert property (@(posedge clk) disable iff (rst)
        (!cfg.run && !load) |=> (count == $past(count)));

    assert_div_one_R2: assert property (@(posedge clk) disable iff (rst)
        (cfg.run && !load && cfg.div_sel == '0) |=> (count == $past(count) + CNT_W'(1)));

endmodule

// File: rtl/oc_compare_bank.sv
`timescale 1ns/1ps
module oc_compare_bank #(
    parameter int N_CH  = 8,
    parameter int CNT_W = 16
) (
    input  logic                       step,
    input  logic [CNT_W-1:0]           next_count,
    input  logic [N_CH-1:0][CNT_W-1:0] cmp_vals,
    input  logic [N_CH-1:0]            oc_mode,
    output logic [N_CH-1:0]            hit
);
    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        assign hit[i] = step && oc_mode[i] && (cmp_vals[i] == next_count);
    end
endmodule

// File: rtl/oc_pin_ctrl.sv
`timescale 1ns/1ps
module oc_pin_ctrl
    import oc_timer_pkg::*;
#(
    parameter int N_CH = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [N_CH-1:0]       hit,
    input  logic [N_CH-1:0][1:0]  act_cfg,
    input  logic [N_CH-1:0]       force_mask,
    input  logic [N_CH-1:0]       force_data,
    output logic [N_CH-1:0]       pins
);
    localparam int FORCE_CH = N_CH - 1;

    logic [N_CH-1:0] pins_n;

    always_comb begin
        pins_n = pins;
        for (int k = 0; k < N_CH; k++) begin
            if (hit[k]) pins_n[k] = apply_act(pin_act_e'(act_cfg[k]), pins[k]);
        end
        if (hit[FORCE_CH]) pins_n = (pins_n & ~force_mask) | (force_data & force_mask);
    end

    always_ff @(posedge clk) begin
        if (rst) pins <= '0;
        else     pins <= pins_n;
    end

    assert_force_wins_R7: assert property (@(posedge clk) disable iff (rst)
        hit[FORCE_CH] |=> (((pins ^ $past(force_data)) & $past(force_mask)) == '0));

    assert_quiet_pins_R5: assert property (@(posedge clk) disable iff (rst)
        (hit == '0) |=> $stable(pins));

    for (genvar k = 0; k < N_CH; k++) begin : g_chk
        assert_drive_high_R5: assert property (@(posedge clk) disable iff (rst)
            (hit[k] && act_cfg[k] == ACT_HIGH && !(hit[FORCE_CH] && force_mask[k])) |=> pins[k]);
        assert_toggle_R5: assert property (@(posedge clk) disable iff (rst)
            (hit[k] && act_cfg[k] == ACT_TOGGLE && !(hit[FORCE_CH] && force_mask[k]))
            |=> (pins[k] != $past(pins[k])));
    end

endmodule

// File: rtl/oc_timer_bank.sv
`timescale 1ns/1ps
module oc_timer_bank
    import oc_timer_pkg::*;
#(
    parameter int N_CH   = 8,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic [N_CH-1:0]   pin_out,
    output logic [N_CH-1:0]   irq
);
    localparam int CMP_BASE = 1 << (ADDR_W - 1);
    localparam int ACT_W    = 2 * N_CH;

    tb_cfg_t                    cfg_q;
    logic [N_CH-1:0]            mode_q, flags_q, ien_q, fmask_q, fdata_q;
    logic [N_CH-1:0][1:0]       act_q;
    logic [N_CH-1:0][CNT_W-1:0] cmp_q;
    logic [CNT_W-1:0]           count, next_count;
    logic                       step, load;
    logic [N_CH-1:0]            hit, clr;

    function automatic logic wr_at(int a);
        return bus_we && (bus_addr == ADDR_W'(a));
    endfunction

    assign load = wr_at(ADR_COUNT);
    assign clr  = wr_at(ADR_FLAG) ? bus_wdata[N_CH-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            mode_q  <= '0;
            flags_q <= '0;
            ien_q   <= '0;
            act_q   <= '0;
            fmask_q <= '0;
            fdata_q <= '0;
            cmp_q   <= '0;
        end else begin
            if (wr_at(ADR_CTRL))  cfg_q.run     <= bus_wdata[RUN_BIT];
            if (wr_at(ADR_DIV))   cfg_q.div_sel <= bus_wdata[DIV_W-1:0];
            if (wr_at(ADR_MODE))  mode_q        <= bus_wdata[N_CH-1:0];
            if (wr_at(ADR_IEN))   ien_q         <= bus_wdata[N_CH-1:0];
            if (wr_at(ADR_ACT))   act_q         <= bus_wdata[ACT_W-1:0];
            if (wr_at(ADR_FMASK)) fmask_q       <= bus_wdata[N_CH-1:0];
            if (wr_at(ADR_FDATA)) fdata_q       <= bus_wdata[N_CH-1:0];
            for (int i = 0; i < N_CH; i++) begin
                if (wr_at(CMP_BASE + i)) cmp_q[i] <= bus_wdata;
            end
            flags_q <= (flags_q & ~clr) | hit;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(ADR_CTRL):  bus_rdata[RUN_BIT] = cfg_q.run;
            ADDR_W'(ADR_DIV):   bus_rdata = CNT_W'(cfg_q.div_sel);
            ADDR_W'(ADR_MODE):  bus_rdata = CNT_W'(mode_q);
            ADDR_W'(ADR_FLAG):  bus_rdata = CNT_W'(flags_q);
            ADDR_W'(ADR_IEN):   bus_rdata = CNT_W'(ien_q);
            ADDR_W'(ADR_ACT):   bus_rdata = CNT_W'(act_q);
            ADDR_W'(ADR_FMASK): bus_rdata = CNT_W'(fmask_q);
            ADDR_W'(ADR_FDATA): bus_rdata = CNT_W'(fdata_q);
            ADDR_W'(ADR_COUNT): bus_rdata = count;
            default: begin
                for (int i = 0; i < N_CH; i++) begin
                    if (bus_addr == ADDR_W'(CMP_BASE + i)) bus_rdata = cmp_q[i];
                end
            end
        endcase
    end

    assign irq = flags_q & ien_q;

    oc_timebase #(.CNT_W(CNT_W)) u_timebase (
        .clk        (clk),
        .rst        (rst),
        .cfg        (cfg_q),
        .load       (load),
        .load_val   (bus_wdata),
        .count      (count),
        .step       (step),
        .next_count (next_count)
    );

    oc_compare_bank #(.N_CH(N_CH), .CNT_W(CNT_W)) u_compare (
        .step       (step),
        .next_count (next_count),
        .cmp_vals   (cmp_q),
        .oc_mode    (mode_q),
        .hit        (hit)
    );

    oc_pin_ctrl #(.N_CH(N_CH)) u_pins (
        .clk        (clk),
        .rst        (rst),
        .hit        (hit),
        .act_cfg    (act_q),
        .force_mask (fmask_q),
        .force_data (fdata_q),
        .pins       (pin_out)
    );

    assert_one_per_step_R9: assert property (@(posedge clk) disable iff (rst)
        (|hit) |=> (count != $past(count)));

    for (genvar i = 0; i < N_CH; i++) begin : g_chk
        assert_flag_on_match_R4: assert property (@(posedge clk) disable iff (rst)
            hit[i] |=> (flags_q[i] && count == $past(cmp_q[i])));
        assert_capture_quiet_R3: assert property (@(posedge clk) disable iff (rst)
            !mode_q[i] |-> !hit[i]);
    end

endmodule

// File: tb/oc_timer_bank_bench.sv
`timescale 1ns/1ps
module oc_timer_bank_bench;

    localparam int A_CTRL = 0, A_DIV = 1, A_MODE = 2, A_FLAG = 3, A_IEN = 4;
    localparam int A_ACT = 5, A_FMASK = 6, A_FDATA = 7, A_COUNT = 8, A_CMP = 16;

    // divider select, clocks waited after start, expected count
    localparam logic [26:0] VEC [0:5] = '{
        {3'd0, 8'd7,  16'd7},
        {3'd2, 8'd9,  16'd2},
        {3'd2, 8'd8,  16'd2},
        {3'd1, 8'd5,  16'd2},
        {3'd3, 8'd20, 16'd2},
        {3'd0, 8'd1,  16'd1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [7:0]  pin_out, irq;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] held;

    always #10 clk = ~clk;

    oc_timer_bank u_oc_timer_bank (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_out(pin_out), .irq(irq)
    );

    task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(int a, logic [15:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 5'(a); bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(int a, logic [15:0] exp, string tag);
        bus_addr = 5'(a);
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic waitn(int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic setup();
        wr(A_CTRL, 16'h0000);
        wr(A_FLAG, 16'h00FF);
        wr(A_COUNT, 16'h0000);
    endtask

    task automatic go();
        wr(A_CTRL, 16'h0080);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        #4_000_000;
        n_chk++; n_bad++;
        $display("FAIL R11 watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11 reset state
        for (int a = 0; a <= A_COUNT; a++) rd(a, 16'h0, "R11 register reset");
        rd(A_CMP + 7, 16'h0, "R11 compare reset");
        chk("R11 pins reset", 16'(pin_out), 16'h0);
        chk("R11 irq reset", 16'(irq), 16'h0);

        // R1 R2 divider table
        for (int v = 0; v < 6; v++) begin
            wr(A_CTRL, 16'h0000);
            wr(A_DIV, 16'(VEC[v][26:24]));
            wr(A_COUNT, 16'h0000);
            go();
            waitn(int'(VEC[v][23:16]));
            rd(A_COUNT, VEC[v][15:0], "R2 divider step count");
        end

        // R1 hold while stopped
        wr(A_CTRL, 16'h0000);
        bus_addr = 5'(A_COUNT); #1; held = bus_rdata;
        waitn(5);
        rd(A_COUNT, held, "R1 counter held when stopped");

        // R1 wrap
        setup();
        wr(A_DIV, 16'h0000);
        wr(A_COUNT, 16'hFFFE);
        go();
        waitn(3);
        rd(A_COUNT, 16'h0001, "R1 counter wraps");

        // R3 capture mode is silent
        setup();
        wr(A_MODE, 16'h0000);
        wr(A_CMP + 0, 16'd5);
        go();
        waitn(8);
        rd(A_FLAG, 16'h0, "R3 capture channel no flag");
        chk("R3 capture channel no pin", 16'(pin_out), 16'h0);

        // R4 flag set and write-one-to-clear
        setup();
        wr(A_MODE, 16'h0001);
        go();
        waitn(8);
        rd(A_COUNT, 16'd8, "R4 count at check");
        rd(A_FLAG, 16'h0001, "R4 flag set on match");
        wr(A_FLAG, 16'h0000);
        rd(A_FLAG, 16'h0001, "R4 writing zero keeps flag");
        wr(A_FLAG, 16'h0001);
        rd(A_FLAG, 16'h0000, "R4 writing one clears flag");

        // R8 interrupt request
        setup();
        go();
        waitn(8);
        chk("R8 irq off without enable", 16'(irq), 16'h0);
        wr(A_IEN, 16'h0001);
        chk("R8 irq with flag and enable", 16'(irq), 16'h0001);
        wr(A_FLAG, 16'h0001);
        chk("R8 irq drops with flag", 16'(irq), 16'h0);

        // R5 R9 toggle once with divide by four
        setup();
        wr(A_DIV, 16'd2);
        wr(A_ACT, 16'h0001);
        wr(A_CMP + 0, 16'd3);
        go();
        waitn(14);
        chk("R9 toggle once at match", 16'(pin_out[0]), 16'h1);
        waitn(16);
        rd(A_COUNT, 16'd7, "R2 divide by four count");
        chk("R9 no second toggle", 16'(pin_out[0]), 16'h1);

        // R5 drive high on channels 1..3
        setup();
        wr(A_DIV, 16'd0);
        wr(A_MODE, 16'h000E);
        wr(A_ACT, 16'h00FC);
        wr(A_CMP + 1, 16'd4);
        wr(A_CMP + 2, 16'd4);
        wr(A_CMP + 3, 16'd4);
        go();
        waitn(6);
        chk("R5 drive high", 16'(pin_out), 16'h000F);

        // R5 high, low, none
        setup();
        wr(A_ACT, 16'h002C);
        go();
        waitn(6);
        chk("R5 low and none codes", 16'(pin_out), 16'h000B);

        // R6 R7 force with same-step conflict
        setup();
        wr(A_MODE, 16'h00C0);
        wr(A_ACT, 16'h3000);
        wr(A_FMASK, 16'h0044);
        wr(A_FDATA, 16'h0004);
        wr(A_CMP + 6, 16'd5);
        wr(A_CMP + 7, 16'd5);
        go();
        waitn(7);
        chk("R7 forced low beats drive high", 16'(pin_out[6]), 16'h0);
        chk("R6 masked pin forced high", 16'(pin_out[2]), 16'h1);
        chk("R6 unmasked pins kept", 16'(pin_out), 16'h000F);

        // R10 pulse train
        setup();
        wr(A_FMASK, 16'h0040);
        wr(A_FDATA, 16'h0000);
        wr(A_CMP + 7, 16'd20);
        wr(A_CMP + 6, 16'd28);
        go();
        waitn(24);
        chk("R10 low after period match", 16'(pin_out[6]), 16'h0);
        waitn(6);
        chk("R10 high after width match", 16'(pin_out[6]), 16'h1);
        wr(A_CMP + 7, 16'd40);
        wr(A_CMP + 6, 16'd48);
        waitn(8);
        chk("R10 second period low", 16'(pin_out[6]), 16'h0);
        waitn(8);
        chk("R10 second width high", 16'(pin_out[6]), 16'h1);

        summary();
        $finish;
    end

endmodule